// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps a self-refreshing pseudo-static DRAM on a serial DDR bus alive when its internal refresh cannot be trusted. Reading or writing any location opens a row, copies it to the device's row buffer and writes it back when the access ends. A one-location access to a row is therefore enough to refresh that row. The scheduler produces those accesses. It walks a row pointer through the array and asks a downstream transaction engine for one minimal access per row. The requests are spread so that the whole array is covered within a refresh interval set in clock cycles.

Each row gets a slot of `INTERVAL_CYC / ROWS` cycles. In the second half of its slot, a row is offered for refresh only while the display is blanking or no requester wants the bus, and never while the engine is busy. If the slot runs out without a grant, an urgent flag rises and the request goes out as soon as the engine is free, whatever the idle input says. A catch-up command runs an unconditional sweep over every row, from first to last, with the requests back to back. This covers rows that the device may have skipped during long chip-select-low transfers. A pulse marks the end of the sweep.

The request is a request/grant handshake. The address is the row number shifted up past the column bits, with the column bits at zero.

Top module: `rfs_sched`

## Requirements
- R1: While reset is held and just after it is released, `ref_req`, `ref_urgent`, `sweep_active` and `catch_done` are 0, and `ref_addr` is 0.
- R2: `ref_addr` equals the row number times 2^COL_W, with its low COL_W bits at zero.
- R3: With `bus_idle`=1 and `eng_busy`=0, `ref_req` rises on the (EARLY+1)-th clock edge after the last normal grant, where EARLY = PER_ROW/2 and PER_ROW = INTERVAL_CYC/ROWS.
- R4: With `bus_idle`=0 and `eng_busy`=0, `ref_urgent` rises PER_ROW edges after the last normal grant, and `ref_req` rises on the next edge.
- R5: No request is raised while `eng_busy`=1. Once raised, `ref_req` and `ref_addr` hold until the clock edge on which `ref_gnt`=1.
- R6: Each normal grant advances the row pointer by one, and the pointer wraps from ROWS-1 to 0.
- R7: A `catch_up` pulse starts a sweep that requests rows 0 to ROWS-1 in order. The sweep ignores `bus_idle` and waits only while `eng_busy`=1. `sweep_active` is 1 for the whole sweep.
- R8: `catch_done` is 1 for exactly one cycle after the grant of the last sweep row. `sweep_active` is 0 in that same cycle.
- R9: A `catch_up` pulse while a sweep is running has no effect: the sweep continues in order and ends once.
- R10: A sweep leaves the normal row pointer unchanged. The normal slot timer restarts from zero when the sweep's last grant is taken.
- R11: `ref_urgent` falls on the normal grant and does not return until a full slot has passed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_idle | input | 1 | Blanking or no requester waiting; preferred window |
| eng_busy | input | 1 | Transaction engine is occupied; no new request |
| catch_up | input | 1 | Pulse: start a full-array sweep |
| ref_gnt | input | 1 | Engine accepts the current request |
| ref_req | output | 1 | Refresh access request |
| ref_addr | output | $clog2(ROWS)+COL_W | Row base address, column bits zero |
| ref_urgent | output | 1 | Current row's slot has expired |
| sweep_active | output | 1 | A catch-up sweep is in progress |
| catch_done | output | 1 | One-cycle pulse at sweep end |

## Verification
A normal request can be granted on the same clock edge on which a catch-up pulse arrives. In that cycle the scheduler must credit the grant to the normal pointer and restart the slot timer, and also open the sweep. The bench provokes this by driving `catch_up` on the edge where it grants a pending normal request. It then checks that the next request carries row 0 of the sweep, that the sweep runs to its end, and that the normal request after the sweep carries the following row. A second overlap is a catch-up pulse that arrives on the grant edge of a sweep row in the middle of a sweep. It is judged by the next address, which must continue the sequence rather than restart it.

// File: rtl/rfs_pkg.sv
// Shared types for the row refresh scheduler.
// Assumes: one outstanding request at a time; the source tag travels with it.
package rfs_pkg;
    typedef enum logic {
        SRC_ROW   = 1'b0,   // request from the distributed row pointer
        SRC_SWEEP = 1'b1    // request from a catch-up sweep
    } rfs_src_e;
endpackage

// File: rtl/rfs_slot_timer.sv
// Slot timer: counts cycles since the last normal refresh grant.
// Reports "due" from EARLY cycles on and "overdue" once PER_ROW is reached.
// Assumes PER_ROW >= 2 and EARLY < PER_ROW. Saturates at PER_ROW.
module rfs_slot_timer #(
    parameter int PER_ROW = 64,
    parameter int EARLY   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic hold,
    output logic due,
    output logic overdue
);
    localparam int TW = $clog2(PER_ROW + 1);
    localparam logic [TW-1:0] LIM   = TW'(PER_ROW);
    localparam logic [TW-1:0] EARLY_V = TW'(EARLY);

    logic [TW-1:0] cnt_q;

    // count since last grant, cleared on grant or while a sweep runs
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart || hold)  cnt_q <= '0;
        else if (cnt_q != LIM)     cnt_q <= cnt_q + 1'b1;
    end

    assign due     = (cnt_q >= EARLY_V);
    assign overdue = (cnt_q == LIM);

    // R11
    overdue_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overdue && !restart && !hold |=> overdue);

    // R4
    overdue_after_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overdue) |-> $past(due));
endmodule

// File: rtl/rfs_row_ptr.sv
// Row pointer: steps modulo ROWS, with a synchronous clear.
// Used for the distributed pointer and for the sweep position.
// Assumes ROWS >= 2.
module rfs_row_ptr #(
    parameter int ROWS = 8192,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clear,
    output logic [RW-1:0] row,
    output logic          at_last
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    logic [RW-1:0] row_q;

    // advance on each accepted access, wrapping at the last row
    always_ff @(posedge clk) begin
        if (!rst_n || clear) row_q <= '0;
        else if (step)       row_q <= (row_q == LAST) ? '0 : row_q + 1'b1;
    end

    assign row     = row_q;
    assign at_last = (row_q == LAST);

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= LAST);

    // R6
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !clear |=> $stable(row_q));
endmodule

// File: rtl/rfs_req_ctl.sv
// Request holder: registers one refresh request with its address and
// source tag, and keeps both steady until granted.
// Assumes the grant is only given while the request is high.
module rfs_req_ctl #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] launch_addr,
    input  rfs_pkg::rfs_src_e launch_src,
    input  logic              gnt,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output rfs_pkg::rfs_src_e src
);
    // hold request until grant, load a new one only when empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            addr <= '0;
            src  <= rfs_pkg::SRC_ROW;
        end else if (req && gnt) begin
            req  <= 1'b0;
        end else if (!req && launch) begin
            req  <= 1'b1;
            addr <= launch_addr;
            src  <= launch_src;
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && !gnt |=> req && $stable(addr));

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && gnt |=> !req);
endmodule

// File: rtl/rfs_sched.sv
// Row refresh scheduler top.
// Spreads single-row refresh requests across INTERVAL_CYC, prefers idle
// windows, escalates to urgent when a slot expires, and runs full-array
// catch-up sweeps on command. Assumes the engine grants only while
// ref_req is high and performs a one-location access at ref_addr.
module rfs_sched #(
    parameter int ROWS         = 8192,
    parameter int COL_W        = 9,
    parameter int INTERVAL_CYC = 524288,
    localparam int PER_ROW     = INTERVAL_CYC / ROWS,
    localparam int EARLY       = PER_ROW / 2,
    localparam int RW          = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int ADDR_W      = RW + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_idle,
    input  logic              eng_busy,
    input  logic              catch_up,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic [ADDR_W-1:0] ref_addr,
    output logic              ref_urgent,
    output logic              sweep_active,
    output logic              catch_done
);
    import rfs_pkg::*;

    logic          due, overdue;
    logic [RW-1:0] norm_row, sweep_row;
    logic          norm_last, sweep_last;
    logic          sweeping_q, done_q;
    rfs_src_e      cur_src, pick_src;
    logic          take, take_norm, take_sweep, sweep_start, sweep_end;
    logic          launch;
    logic [RW-1:0] pick_row;
    logic [ADDR_W-1:0] pick_addr;

    assign take        = ref_req && ref_gnt;
    assign take_norm   = take && (cur_src == SRC_ROW);
    assign take_sweep  = take && (cur_src == SRC_SWEEP);
    assign sweep_start = catch_up && !sweeping_q;
    assign sweep_end   = take_sweep && sweep_last;

    rfs_slot_timer #(.PER_ROW(PER_ROW), .EARLY(EARLY)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .restart(take_norm), .hold(sweeping_q),
        .due(due), .overdue(overdue)
    );

    rfs_row_ptr #(.ROWS(ROWS)) u_norm_ptr (
        .clk(clk), .rst_n(rst_n),
        .step(take_norm), .clear(1'b0),
        .row(norm_row), .at_last(norm_last)
    );

    rfs_row_ptr #(.ROWS(ROWS)) u_sweep_ptr (
        .clk(clk), .rst_n(rst_n),
        .step(take_sweep), .clear(sweep_start),
        .row(sweep_row), .at_last(sweep_last)
    );

    // sweep state: start on command when not running, stop after last row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweeping_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= sweep_end;
            if (sweep_start)    sweeping_q <= 1'b1;
            else if (sweep_end) sweeping_q <= 1'b0;
        end
    end

    // source choice: sweep first, then expired slot, then idle window
    always_comb begin
        launch   = 1'b0;
        pick_src = SRC_ROW;
        pick_row = norm_row;
        if (!eng_busy) begin
            if (sweeping_q) begin
                launch   = 1'b1;
                pick_src = SRC_SWEEP;
                pick_row = sweep_row;
            end else if (overdue || (due && bus_idle)) begin
                launch   = 1'b1;
            end
        end
    end

    // address shape: row base with zero column, or bare row when no column
    generate
        if (COL_W > 0) begin : g_col
            assign pick_addr = {pick_row, {COL_W{1'b0}}};
        end else begin : g_nocol
            assign pick_addr = pick_row;
        end
    endgenerate

    rfs_req_ctl #(.ADDR_W(ADDR_W)) u_req (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_addr(pick_addr), .launch_src(pick_src),
        .gnt(ref_gnt),
        .req(ref_req), .addr(ref_addr), .src(cur_src)
    );

    assign ref_urgent   = overdue;
    assign sweep_active = sweeping_q;
    assign catch_done   = done_q;

    // R5
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) |-> !$past(eng_busy));

    // R3
    idle_pref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) && !$past(overdue) && !$past(sweeping_q) |-> $past(bus_idle));

    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sweep_active) |-> catch_done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        catch_done |=> !catch_done);

    // R9
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_active) |-> $past(catch_up));
endmodule

// File: tb/rfs_sched_tb.sv
// Bench for the row refresh scheduler with small parameters:
// ROWS=8, COL_W=3, INTERVAL_CYC=128 -> PER_ROW=16, EARLY=8.
module rfs_sched_tb;
    localparam int ROWS = 8;
    localparam int COLW = 3;
    localparam int INTV = 128;
    localparam int PR   = INTV / ROWS;
    localparam int ER   = PR / 2;
    localparam int AW   = $clog2(ROWS) + COLW;
    localparam int WIN  = 2 * PR + 4;
    localparam int NV   = 10;
    // vector table: idle, busy, expected latency in cycles (0 = none)
    localparam int V_IDLE [NV] = '{1, 0, 0, 1, 1, 0, 1, 1, 1, 1};
    localparam int V_BUSY [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 0};
    localparam int V_LAT  [NV] = '{ER+2, PR+2, 0, 0, ER+2, PR+2, ER+2, ER+2, ER+2, ER+2};

    logic clk = 1'b0;
    logic rst_n, bus_idle, eng_busy, catch_up, ref_gnt;
    logic ref_req, ref_urgent, sweep_active, catch_done;
    logic [AW-1:0] ref_addr;

    int total = 0;
    int bad = 0;
    int exp_row = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rfs_sched #(.ROWS(ROWS), .COL_W(COLW), .INTERVAL_CYC(INTV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .eng_busy(eng_busy),
        .catch_up(catch_up), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ref_addr(ref_addr), .ref_urgent(ref_urgent),
        .sweep_active(sweep_active), .catch_done(catch_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // count negedges until ref_req; lat starts at 1 on the current negedge
    task automatic wait_req(output int lat);
        lat = 1;
        while (!ref_req && lat < WIN) begin
            @(negedge clk);
            lat++;
        end
        if (!ref_req) lat = 0;
    endtask

    // one-cycle grant, inputs for the next phase set on the same negedge
    task automatic grant(input logic idle_v, input logic busy_v, input logic cu);
        ref_gnt = 1'b1; bus_idle = idle_v; eng_busy = busy_v; catch_up = cu;
        @(negedge clk);
        ref_gnt = 1'b0; catch_up = 1'b0;
    endtask

    // grant all sweep rows; optional catch_up at row mid
    task automatic run_sweep(input int mid);
        int lat;
        for (int i = 0; i < ROWS; i++) begin
            if (i == 5) begin
                for (int k = 0; k < 4; k++) begin
                    check("R5 no request while busy in sweep", ref_req, 0);
                    @(negedge clk);
                end
                eng_busy = 1'b0;
            end
            wait_req(lat);
            check("R7 sweep request seen", int'(ref_req), 1);
            check("R7 sweep address order", int'(ref_addr), i << COLW);
            check("R7 sweep active", sweep_active, 1);
            check("R8 no early done", catch_done, 0);
            grant(1'b0, (i == 4), (i == mid));
        end
        check("R8 done pulse", catch_done, 1);
        check("R8 sweep ended", sweep_active, 0);
        @(negedge clk);
        check("R8 done single cycle", catch_done, 0);
    endtask

    initial begin
        int lat;
        rst_n = 1'b0; bus_idle = 1'b1; eng_busy = 1'b0; catch_up = 1'b0; ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 req in reset", ref_req, 0);
        check("R1 urgent in reset", ref_urgent, 0);
        check("R1 sweep in reset", sweep_active, 0);
        check("R1 done in reset", catch_done, 0);
        check("R1 addr in reset", int'(ref_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after release", ref_req, 0);
        wait_req(lat);
        check("R3 first idle latency", lat + 1, ER + 2);
        check("R2 first address row 0", int'(ref_addr), 0);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            if (!ref_req) begin
                bus_idle = 1'b1; eng_busy = 1'b0;
                wait_req(lat);
            end
            check("R6 R2 address of row", int'(ref_addr), exp_row << COLW);
            grant(V_IDLE[v] != 0, V_BUSY[v] != 0, 1'b0);
            exp_row = (exp_row + 1) % ROWS;
            check("R11 urgent clear after grant", ref_urgent, 0);
            wait_req(lat);
            if (V_BUSY[v] != 0) check("R5 held off while busy", lat, 0);
            else if (V_IDLE[v] != 0) check("R3 idle latency", lat, V_LAT[v]);
            else check("R4 urgent latency", lat, V_LAT[v]);
            if (V_LAT[v] == PR + 2 || V_BUSY[v] != 0)
                check("R4 urgent flag raised", ref_urgent, 1);
        end

        // held request under busy and no idle
        if (!ref_req) begin
            bus_idle = 1'b1; eng_busy = 1'b0;
            wait_req(lat);
        end
        eng_busy = 1'b1; bus_idle = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R5 request held", ref_req, 1);
            check("R5 address held", int'(ref_addr), exp_row << COLW);
        end
        // grant normal request together with catch_up (coincidence)
        grant(1'b0, 1'b0, 1'b1);
        exp_row = (exp_row + 1) % ROWS;
        run_sweep(3);
        // after sweep: normal pointer unchanged, timer restarted
        bus_idle = 1'b1;
        // catch_done negedge was lat 1, one more negedge elapsed
        wait_req(lat);
        check("R10 restart latency after sweep", lat + 1, ER + 2);
        check("R10 normal pointer kept", int'(ref_addr), exp_row << COLW);
        grant(1'b0, 1'b0, 1'b0);
        exp_row = (exp_row + 1) % ROWS;
        // catch_up with no request pending, idle low
        catch_up = 1'b1;
        @(negedge clk);
        catch_up = 1'b0;
        run_sweep(6);
        bus_idle = 1'b1;
        wait_req(lat);
        check("R10 pointer kept after second sweep", int'(ref_addr), exp_row << COLW);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule